// File: doc/BRIEF.md
# Processor Run Control Unit

This block sits between a host register bus and one attached processing core. It holds the word that asks the core to run or to stop, a status word that tells the host whether the core is running, and the address at which the core will resume. The host starts the core by writing the run code, and it stops the core by writing the stop code. A stop is a handshake. The block raises a stop request to the core and holds it until the core answers with a stopped pulse. Only then does the running state drop.

The resume address is protected. The host can change it only while the core is stopped, and the stored value is trimmed by a fixed mask. While the core runs, a read of that register returns zero. The isolated flag in the status word is set by the core side. A run request leaves that flag as it is and clears every other status bit apart from the running bit, which it sets.

Bus accesses are single-beat. The host drives a request for one cycle. The response (read data, a response-valid strobe for reads and a one-cycle error flag) appears on the next cycle.

Top module: `run_ctl_unit`

## Requirements
- R1: After reset the running output, the stop request, the error flag and the response strobe are all low, and the control word, status word and resume address all read as zero.
- R2: A write of 1 (run) at byte offset 0x0 while not running sets status bit 0 (running), clears status bit 1 and keeps status bit 7. While running, such a write changes no status bit.
- R3: A write at offset 0x8 while not running stores the written value ANDed with 0x3FFFD.
- R4: A write at offset 0x8 while running is ignored, and the stored resume address keeps its value.
- R5: A read at offset 0x8 returns zero while running and the stored value while stopped, judged on the state in the cycle of the request.
- R6: A write of 0 (stop) at offset 0x0 while running raises the stop request on the next cycle. The request stays high until a cycle with the stopped input high. That edge clears the running bit, drops the request and sets status bit 1 (stopped on request).
- R7: A read at offset 0x0 returns the last accepted control value. A write of any other value than 0 or 1 is rejected with the error flag, and the stored value is kept.
- R8: An access at any offset other than 0x0, 0x4 and 0x8, or a write at 0x4 (status, read-only), raises the error flag for one cycle. A read that errs returns zero data.
- R9: A pulse on the isolate input sets status bit 7, which stays set until reset.
- R10: Every read is answered by the response strobe exactly one cycle after the request, and a write gives no strobe.
- R11: The stopped input while running, with no stop request pending, clears the running bit without setting status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |
| rsp_err | output | 1 | One-cycle error for a rejected access |
| core_run | output | 1 | Core may execute |
| core_stop_req | output | 1 | Stop request to the core |
| core_stopped | input | 1 | Core acknowledges it has stopped |
| core_iso_set | input | 1 | Core enters isolated state |

## Verification
The assertions check these rules on every cycle:
- the resume address never moves while running;
- the stop request holds until it is acknowledged;
- a stop request is never seen without the running bit;
- a run start always clears the stopped-on-request bit;
- a running-time resume-address read returns zero;
- an erring read returns zero data.

Some behaviour shows only in the bench's scenarios. The bench compares every response, and the running and stop outputs, against a reference model under random mixes of bus traffic and core acknowledgements. This covers:
- the trimmed value of the resume address;
- the control readback after a rejected write;
- the isolated bit surviving a restart;
- races such as a stop write in the same cycle as a stopped pulse.

// File: rtl/run_ctl_unit.sv
module run_ctl_unit #(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] NPC_MASK = 32'h0003_FFFD,
  parameter int          ISO_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              core_run,
  output logic              core_stop_req,
  input  logic              core_stopped,
  input  logic              core_iso_set
);

  localparam logic [ADDR_W-1:0] OFS_CTL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_NPC  = ADDR_W'(8);
  localparam logic [DATA_W-1:0] CODE_RUN  = DATA_W'(1);
  localparam logic [DATA_W-1:0] CODE_STOP = DATA_W'(0);
  localparam logic [DATA_W-1:0] MASK_W    = DATA_W'(NPC_MASK);

  logic              run_q, stop_q, halt_q, iso_q;
  logic [DATA_W-1:0] npc_q, ctl_q;
  logic              npc_rd_run_q;

  wire wr = req_valid & req_write;
  wire rd = req_valid & ~req_write;

  wire hit_ctl  = req_addr == OFS_CTL;
  wire hit_stat = req_addr == OFS_STAT;
  wire hit_npc  = req_addr == OFS_NPC;

  wire code_ok  = (req_wdata == CODE_RUN) | (req_wdata == CODE_STOP);
  wire ctl_wr   = wr & hit_ctl & code_ok;
  wire run_go   = ctl_wr & (req_wdata == CODE_RUN) & ~run_q;
  wire stop_go  = ctl_wr & (req_wdata == CODE_STOP) & run_q;
  wire run_clr  = run_q & core_stopped;
  wire npc_wr   = wr & hit_npc & ~run_q;

  wire bad = req_valid & (~(hit_ctl | hit_stat | hit_npc)
                          | (wr & hit_stat)
                          | (wr & hit_ctl & ~code_ok));

  logic [DATA_W-1:0] status;
  always_comb begin
    status = '0;
    status[0] = run_q;
    status[1] = halt_q;
    status[ISO_BIT] = iso_q;
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_ctl)  rd_mux = ctl_q;
    if (hit_stat) rd_mux = status;
    if (hit_npc)  rd_mux = run_q ? '0 : npc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      stop_q <= 1'b0;
      halt_q <= 1'b0;
      iso_q  <= 1'b0;
    end else begin
      if (run_clr)     run_q <= 1'b0;
      else if (run_go) run_q <= 1'b1;

      if (run_clr)      stop_q <= 1'b0;
      else if (stop_go) stop_q <= 1'b1;

      if (run_clr && stop_q) halt_q <= 1'b1;
      else if (run_go)       halt_q <= 1'b0;

      if (core_iso_set) iso_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      npc_q <= '0;
      ctl_q <= '0;
    end else begin
      if (npc_wr) npc_q <= req_wdata & MASK_W;
      if (ctl_wr) ctl_q <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_err      <= 1'b0;
      rsp_rdata    <= '0;
      npc_rd_run_q <= 1'b0;
    end else begin
      rsp_valid    <= rd;
      rsp_err      <= bad;
      rsp_rdata    <= (rd && !bad) ? rd_mux : '0;
      npc_rd_run_q <= rd & hit_npc & run_q;
    end
  end

  assign core_run      = run_q;
  assign core_stop_req = stop_q;

  p_npc_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(npc_q));

  p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_stop_req && !core_stopped) |=> core_stop_req);

  p_stop_needs_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    core_stop_req |-> core_run);

  p_start_clears_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_run) |-> !halt_q);

  p_npc_rd_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    npc_rd_run_q |-> (rsp_rdata == '0));

  p_err_rdata_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_err && rsp_valid) |-> (rsp_rdata == '0));

  p_iso_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    iso_q |=> iso_q);

endmodule

// File: tb/tb_run_ctl_unit.sv
module tb_run_ctl_unit;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [7:0]  req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic        rsp_valid, rsp_err, core_run, core_stop_req;
  logic [31:0] rsp_rdata;
  logic        core_stopped = 0, core_iso_set = 0;

  int checks = 0, fails = 0;
  bit m_run, m_stop, m_halt, m_iso;
  logic [31:0] m_npc, m_ctl;

  always #2 clk = ~clk;

  run_ctl_unit dut (.*);

  function automatic logic [31:0] m_status();
    return {24'b0, m_iso, 5'b0, m_halt, m_run};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(bit v, bit w, logic [7:0] a, logic [31:0] d, bit st, bit iso, string tag);
    bit mapped, err, rd, ok;
    logic [31:0] erd;
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    core_stopped = st; core_iso_set = iso;
    mapped = (a == 0) || (a == 4) || (a == 8);
    ok = (d == 0) || (d == 1);
    err = v && (!mapped || (w && a == 4) || (w && a == 0 && !ok));
    rd = v && !w;
    erd = 0;
    if (rd && !err) erd = (a == 0) ? m_ctl : (a == 4) ? m_status() : (m_run ? 32'h0 : m_npc);
    if (v && w && a == 8 && !m_run) m_npc = d & 32'h3FFFD;
    if (v && w && a == 0 && ok) m_ctl = d;
    if (m_run && st) begin
      if (m_stop) m_halt = 1;
      m_run = 0; m_stop = 0;
    end else if (v && w && a == 0 && d == 1 && !m_run) begin
      m_run = 1; m_halt = 0;
    end else if (v && w && a == 0 && d == 0 && m_run) m_stop = 1;
    if (iso) m_iso = 1;
    @(posedge clk); #1;
    req_valid = 0; core_stopped = 0; core_iso_set = 0;
    chk({tag, " R10 rsp_valid"}, rsp_valid, rd);
    chk({tag, " R8 err"}, rsp_err, err);
    if (rd) chk({tag, " R5/R7 rdata"}, rsp_rdata, erd);
    chk({tag, " R2 run"}, core_run, m_run);
    chk({tag, " R6 stop_req"}, core_stop_req, m_stop);
  endtask

  task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string tag);
    step(1, 0, a, 0, 0, 0, tag);
    chk(tag, rsp_rdata, exp);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    m_run = 0; m_stop = 0; m_halt = 0; m_iso = 0; m_npc = 0; m_ctl = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 run after reset", core_run, 0);
    chk("R1 stop after reset", core_stop_req, 0);
    chk("R1 err after reset", rsp_err, 0);
    rd_chk(8'h4, 0, "R1 status");
    rd_chk(8'h8, 0, "R1 npc");
    rd_chk(8'h0, 0, "R1 ctl");
    step(1, 1, 8'h8, 32'hFFFF_FFFF, 0, 0, "R3 npc write");
    rd_chk(8'h8, 32'h3FFFD, "R3 npc masked");
    step(1, 1, 8'h0, 1, 0, 0, "R2 run");
    rd_chk(8'h4, 32'h1, "R2 status running");
    step(1, 1, 8'h8, 32'h1234, 0, 0, "R4 npc write running");
    rd_chk(8'h8, 0, "R5 npc read running");
    step(1, 1, 8'h0, 0, 0, 0, "R6 stop");
    repeat (3) step(0, 0, 0, 0, 0, 0, "R6 hold");
    chk("R6 held", core_stop_req, 1);
    step(0, 0, 0, 0, 1, 0, "R6 ack");
    rd_chk(8'h4, 32'h2, "R6 halt bit");
    rd_chk(8'h8, 32'h3FFFD, "R4 npc kept");
    step(0, 0, 0, 0, 0, 1, "R9 iso");
    step(1, 1, 8'h0, 1, 0, 0, "R2 restart");
    rd_chk(8'h4, 32'h81, "R2 iso kept");
    step(1, 1, 8'h0, 5, 0, 0, "R7 bad code");
    rd_chk(8'h0, 1, "R7 ctl kept");
    step(1, 0, 8'hC, 0, 0, 0, "R8 unmapped");
    step(1, 1, 8'h4, 3, 0, 0, "R8 status write");
    step(0, 0, 0, 0, 1, 0, "R11 self stop");
    rd_chk(8'h4, 32'h80, "R11 no halt");
    for (int i = 0; i < 800; i++) begin
      bit v, w, st, iso;
      logic [7:0] a;
      logic [31:0] d;
      v = ($urandom % 4) != 0;
      w = $urandom % 2;
      case ($urandom % 8)
        0: a = 8'hC;
        1, 2: a = 8'h4;
        3, 4: a = 8'h8;
        default: a = 8'h0;
      endcase
      d = ($urandom % 4 == 0) ? $urandom : ($urandom % 2);
      if (a == 8) d = $urandom;
      st = ($urandom % 6) == 0;
      iso = ($urandom % 200) == 0;
      step(v, w, a, d, st, iso, "rand");
    end
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule